// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is one output cell of a small programmable logic array. It takes the sum produced by the array's OR gate and turns it into a pin value. The value is either passed straight through or captured in a D flip-flop, then driven with a chosen polarity. The cell also passes on an output-enable for a three-state pin model. One feedback bit goes back to the array. That bit can come from the pin, from the flip-flop or from the raw sum, and this choice does not depend on the output type.

The flip-flop has a synchronous preset and an asynchronous clear, both global terms that arrive from the array. Clear takes priority over preset. A small clock multiplexer picks which clock the flip-flop uses: either the dedicated clock pin or a clock product term, each in true or inverted form. A power-up reset input clears the flip-flop.

All pins are plain control and data levels. There is no streaming interface, so the cell needs no valid/ready handshake and applies no back-pressure.

Top module: `mc_macrocell`

## Requirements
- R1: While `rst_n` is low, the flip-flop is held at 0, so a registered active-high output reads 0. Clock edges during reset capture nothing.
- R2: In registered mode, `pin_out` changes only at a rising edge of the selected clock, where it takes the value of `sum_in`. It does not change when `sum_in` changes between edges.
- R3: When `preset_term` is 1 at a rising edge of the selected clock, the flip-flop becomes 1 at that edge and not earlier.
- R4: When `clear_term` is 1, the flip-flop goes to 0 at once, with no clock edge. If `preset_term` is also 1 at a clock edge, clear still wins and the flip-flop stays 0.
- R5: When `cfg[1]`=0 (combinational mode), `pin_out` follows `sum_in` without waiting for a clock. When `cfg[1]`=1 (registered mode), `pin_out` is taken from the flip-flop.
- R6: When `cfg[0]`=1 the output is active-high and is not inverted. When `cfg[0]`=0 the output is active-low and `pin_out` is the inverse of the selected source.
- R7: `cfg[3:2]` picks the feedback source: 00 gives `pin_in`, 01 gives the flip-flop Q, 10 gives `sum_in`.
- R8: The feedback source does not depend on `cfg[1]`. Register feedback works with a combinational output, and sum feedback works with a registered output.
- R9: `pin_oe` equals `oe_term`. A value of 0 means the pin driver is at high impedance.
- R10: `clk_sel[0]` picks the clock source: 0 is `clk_pin`, 1 is `clk_term`. `clk_sel[1]`=1 inverts the chosen source, so the flip-flop captures on that source's falling edge. The source that is not chosen has no effect.
- R11: Only 12 of the 16 `cfg` codes are legal. Any code with `cfg[3:2]`=11 is illegal, and the cell then behaves as registered, active-high, with feedback from `pin_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Power-up reset, active low, asynchronous; clears the flip-flop |
| clk_pin | input | 1 | Dedicated clock pin |
| clk_term | input | 1 | Clock product term from the array |
| clk_sel | input | 2 | Clock select: bit 0 picks the source, bit 1 inverts it |
| cfg | input | 4 | Cell configuration: [0] polarity, [1] registered, [3:2] feedback source |
| sum_in | input | 1 | OR-gate sum from the array |
| preset_term | input | 1 | Global synchronous preset term |
| clear_term | input | 1 | Global asynchronous clear term |
| oe_term | input | 1 | This cell's output-enable term |
| pin_in | input | 1 | Value sensed on the I/O pin |
| pin_out | output | 1 | Value driven toward the pin |
| pin_oe | output | 1 | Pin driver enable; 0 means high impedance |
| fb_out | output | 1 | Feedback bit returned to the array |

## Verification
The hardest cases to reach are the clock-source changes and the clash between clear and preset. A change of `clk_sel` can itself make a rising edge on the selected clock, so the stimulus changes the selection only at moments when the old and new selected levels make no rising step. The clock product term and the inverted pin clock are then driven as separate, known edges. To show that clear beats preset, a clear pulse is raised in the middle of a cycle while Q is 1. The bench checks that Q falls before any edge, then holds clear and preset together across a real edge. Feedback taken from the register while the output is combinational is checked after Q has first been loaded with 1, so that the value cannot be mistaken for the reset value.

// File: rtl/mc_pkg.sv
`timescale 1ns/1ps
package mc_pkg;
  localparam int CFG_W      = 4;
  localparam int CFG_POL    = 0;  // 1 = active high
  localparam int CFG_REG    = 1;  // 1 = registered output
  localparam int CFG_FB_LO  = 2;  // two-bit feedback select
  localparam int CLK_SEL_W  = 2;
  localparam int CLK_SRC    = 0;  // 1 = product-term clock
  localparam int CLK_INV    = 1;  // 1 = inverted clock

  typedef enum logic [1:0] {
    FB_PIN = 2'b00,
    FB_REG = 2'b01,
    FB_SUM = 2'b10
  } fb_src_e;

  typedef struct packed {
    logic    registered;
    logic    active_high;
    fb_src_e fb_src;
  } cell_mode_t;
endpackage

// File: rtl/mc_clk_select.sv
`timescale 1ns/1ps
module mc_clk_select
  import mc_pkg::*;
(
  input  logic                 clk_pin,
  input  logic                 clk_term,
  input  logic [CLK_SEL_W-1:0] clk_sel,
  output logic                 clk_out
);
  logic src_clk;
  always_comb begin
    src_clk = clk_sel[CLK_SRC] ? clk_term : clk_pin;
    clk_out = src_clk ^ clk_sel[CLK_INV];
  end
endmodule

// File: rtl/mc_cfg_decode.sv
`timescale 1ns/1ps
module mc_cfg_decode
  import mc_pkg::*;
(
  input  logic [CFG_W-1:0] cfg,
  output cell_mode_t       mode
);
  logic [1:0] fb_bits;
  always_comb begin
    fb_bits = cfg[CFG_FB_LO +: 2];
    if (fb_bits == 2'b11) begin
      // illegal code: fall back to registered, active high, pin feedback
      mode.registered  = 1'b1;
      mode.active_high = 1'b1;
      mode.fb_src      = FB_PIN;
    end else begin
      mode.registered  = cfg[CFG_REG];
      mode.active_high = cfg[CFG_POL];
      mode.fb_src      = fb_src_e'(fb_bits);
    end
  end
endmodule

// File: rtl/mc_dff.sv
`timescale 1ns/1ps
module mc_dff #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst,     // active-high asynchronous clear
  input  logic preset,   // synchronous set
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or posedge arst) begin
    if (arst)        q <= RST_VAL;
    else if (preset) q <= 1'b1;
    else             q <= d;
  end
endmodule

// File: rtl/mc_macrocell.sv
`timescale 1ns/1ps
module mc_macrocell
  import mc_pkg::*;
#(
  parameter logic RESET_VALUE = 1'b0
) (
  input  logic                 rst_n,
  input  logic                 clk_pin,
  input  logic                 clk_term,
  input  logic [CLK_SEL_W-1:0] clk_sel,
  input  logic [CFG_W-1:0]     cfg,
  input  logic                 sum_in,
  input  logic                 preset_term,
  input  logic                 clear_term,
  input  logic                 oe_term,
  input  logic                 pin_in,
  output logic                 pin_out,
  output logic                 pin_oe,
  output logic                 fb_out
);
  cell_mode_t mode;
  logic       cell_clk;
  logic       async_clr;
  logic       q_r;
  logic       core_val;

  mc_clk_select u_clk (
    .clk_pin  (clk_pin),
    .clk_term (clk_term),
    .clk_sel  (clk_sel),
    .clk_out  (cell_clk)
  );

  mc_cfg_decode u_dec (
    .cfg  (cfg),
    .mode (mode)
  );

  assign async_clr = clear_term | ~rst_n;

  mc_dff #(.RST_VAL(RESET_VALUE)) u_ff (
    .clk    (cell_clk),
    .arst   (async_clr),
    .preset (preset_term),
    .d      (sum_in),
    .q      (q_r)
  );

  always_comb begin
    core_val = mode.registered ? q_r : sum_in;
    pin_out  = mode.active_high ? core_val : ~core_val;
    pin_oe   = oe_term;
    unique case (mode.fb_src)
      FB_REG:  fb_out = q_r;
      FB_SUM:  fb_out = sum_in;
      default: fb_out = pin_in;
    endcase
  end
endmodule

// File: rtl/mc_macrocell_chk.sv
`timescale 1ns/1ps
module mc_macrocell_chk
  import mc_pkg::*;
(
  input logic                 rst_n,
  input logic                 clk_pin,
  input logic [CLK_SEL_W-1:0] clk_sel,
  input logic [CFG_W-1:0]     cfg,
  input logic                 sum_in,
  input logic                 preset_term,
  input logic                 clear_term,
  input logic                 oe_term,
  input logic                 pin_in,
  input logic                 pin_out,
  input logic                 pin_oe,
  input logic                 fb_out,
  input logic                 q
);
  assert_capture_R2: assert property (@(posedge clk_pin) disable iff (!rst_n)
    (clk_sel == 2'b00 && !preset_term && !clear_term)
      |=> (q == $past(sum_in) || clear_term));

  assert_sync_preset_R3: assert property (@(posedge clk_pin) disable iff (!rst_n)
    (clk_sel == 2'b00 && preset_term && !clear_term) |=> (q || clear_term));

  assert_clear_wins_R4: assert property (@(posedge clk_pin) disable iff (!rst_n)
    clear_term |-> !q);

  assert_comb_follow_R5: assert property (@(posedge clk_pin) disable iff (!rst_n)
    (cfg[3:2] != 2'b11 && !cfg[1] && cfg[0]) |-> (pin_out == sum_in));

  assert_sum_feedback_R7: assert property (@(posedge clk_pin) disable iff (!rst_n)
    (cfg[3:2] == 2'b10) |-> (fb_out == sum_in));

  assert_oe_pass_R9: assert property (@(posedge clk_pin) disable iff (!rst_n)
    pin_oe == oe_term);

  assert_illegal_default_R11: assert property (@(posedge clk_pin) disable iff (!rst_n)
    (cfg[3:2] == 2'b11) |-> (fb_out == pin_in && pin_out == q));
endmodule

bind mc_macrocell mc_macrocell_chk u_chk (
  .rst_n       (rst_n),
  .clk_pin     (clk_pin),
  .clk_sel     (clk_sel),
  .cfg         (cfg),
  .sum_in      (sum_in),
  .preset_term (preset_term),
  .clear_term  (clear_term),
  .oe_term     (oe_term),
  .pin_in      (pin_in),
  .pin_out     (pin_out),
  .pin_oe      (pin_oe),
  .fb_out      (fb_out),
  .q           (q_r)
);

// File: tb/mc_macrocell_tb.sv
`timescale 1ns/1ps
module mc_macrocell_tb;
  logic       rst_n, clk_pin, clk_term;
  logic [1:0] clk_sel;
  logic [3:0] cfg;
  logic       sum_in, preset_term, clear_term, oe_term, pin_in;
  logic       pin_out, pin_oe, fb_out;
  int         n_run, n_fail;
  bit         done;

  mc_macrocell u_dut (
    .rst_n(rst_n), .clk_pin(clk_pin), .clk_term(clk_term), .clk_sel(clk_sel),
    .cfg(cfg), .sum_in(sum_in), .preset_term(preset_term), .clear_term(clear_term),
    .oe_term(oe_term), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .fb_out(fb_out)
  );

  initial clk_pin = 1'b0;
  always #5 clk_pin = ~clk_pin;

  // {cfg[3:0], sum, pin, expected pin_out, expected fb}; flip-flop holds 0
  localparam logic [7:0] VEC [0:9] = '{
    8'b0001_1010, 8'b0000_1101, 8'b0100_0110, 8'b1001_1011, 8'b1011_1001,
    8'b1010_0110, 8'b0011_1101, 8'b1111_1101, 8'b1100_1000, 8'b0110_1010
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    n_run = 0; n_fail = 0; done = 0;
    rst_n = 0; clk_term = 0; clk_sel = 2'b00; cfg = 4'b0011;
    sum_in = 1; preset_term = 0; clear_term = 0; oe_term = 1; pin_in = 0;
    repeat (3) @(negedge clk_pin);
    #1 check("R1 reset holds register at 0", pin_out, 1'b0);
    @(negedge clk_pin);
    rst_n = 1; sum_in = 0; clk_sel = 2'b01;  // product-term clock held low

    // table walk: decode, polarity and feedback with Q = 0
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_pin);
      cfg = VEC[i][7:4]; sum_in = VEC[i][3]; pin_in = VEC[i][2];
      #2;
      check($sformatf("R5/R6/R7/R11 vector %0d pin_out", i), pin_out, VEC[i][1]);
      check($sformatf("R7/R8/R11 vector %0d fb_out", i), fb_out, VEC[i][0]);
    end

    // R2 capture on pin clock
    @(negedge clk_pin);
    cfg = 4'b0011; clk_sel = 2'b00; sum_in = 1;
    #1 check("R2 no change before edge", pin_out, 1'b0);
    @(negedge clk_pin);
    #1 check("R2 captured at edge", pin_out, 1'b1);
    sum_in = 0;
    #1 check("R2 holds between edges", pin_out, 1'b1);
    @(negedge clk_pin);
    #1 check("R2 captured 0", pin_out, 1'b0);

    // R3 synchronous preset
    preset_term = 1;
    #1 check("R3 preset waits for edge", pin_out, 1'b0);
    @(negedge clk_pin);
    #1 check("R3 preset at edge", pin_out, 1'b1);
    preset_term = 0;

    // R4 asynchronous clear with priority
    #2 clear_term = 1;
    #1 check("R4 clear without edge", pin_out, 1'b0);
    preset_term = 1;
    @(negedge clk_pin);
    #1 check("R4 clear beats preset", pin_out, 1'b0);
    clear_term = 0; preset_term = 0; sum_in = 1;
    @(negedge clk_pin);
    #1 check("R4 released, capture resumes", pin_out, 1'b1);

    // R1 reset mid-run
    rst_n = 0;
    #1 check("R1 async reset clears", pin_out, 1'b0);
    @(negedge clk_pin);
    #1 check("R1 edge ignored in reset", pin_out, 1'b0);
    rst_n = 1;
    @(negedge clk_pin);  // sum_in = 1 captured
    #1;

    // R8 feedback independent of output type (Q = 1)
    cfg = 4'b0101; sum_in = 0;
    #1 check("R8 reg feedback with comb output: fb", fb_out, 1'b1);
    check("R8 reg feedback with comb output: out", pin_out, 1'b0);
    cfg = 4'b1011;
    #1 check("R8 sum feedback with registered output: fb", fb_out, 1'b0);
    check("R8 sum feedback with registered output: out", pin_out, 1'b1);

    // R5 combinational follows without edge
    cfg = 4'b0001; sum_in = 1;
    #1 check("R5 comb follows high", pin_out, 1'b1);
    sum_in = 0;
    #1 check("R5 comb follows low", pin_out, 1'b0);

    // R9 output enable
    oe_term = 0;
    #1 check("R9 disabled", pin_oe, 1'b0);
    oe_term = 1;
    #1 check("R9 enabled", pin_oe, 1'b1);

    // R10 clock selection
    @(negedge clk_pin);
    cfg = 4'b0011; sum_in = 0;
    @(negedge clk_pin);      // Q = 0
    clk_sel = 2'b01; sum_in = 1;
    @(negedge clk_pin);
    #1 check("R10 pin clock ignored with term source", pin_out, 1'b0);
    clk_term = 1;
    #1 check("R10 term clock captures", pin_out, 1'b1);
    sum_in = 0; clk_sel = 2'b11;
    #1 clk_term = 0;
    #1 check("R10 inverted term clock captures on fall", pin_out, 1'b0);
    clk_sel = 2'b10; sum_in = 1;
    @(posedge clk_pin);
    #1 check("R10 inverted pin clock ignores rise", pin_out, 1'b0);
    @(negedge clk_pin);
    #1 check("R10 inverted pin clock captures on fall", pin_out, 1'b1);
    clk_sel = 2'b00;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule